// File: doc/BRIEF.md
# Pulse-Width Power-Level Indicator Decoder

This block sits on the host side of a powered-device power interface. The interface controller reports how much power the sourcing equipment has granted on a single open-drain indicator line. That line can be held high, held low, or toggled at roughly 690 to 990 Hz with one of three low-time fractions. The block samples the line after a synchronizer. It measures each period between falling edges and the low time inside it, and it sorts the result into one of six line states: steady high, steady low, 75 %, 50 % or 25 % low time, or out-of-window error.

A line with no edges for a timeout of three maximum periods is reported as a steady level. The decoded state is combined with the configured requested class, an auxiliary-supply mode input and a source-family input. From these the block produces a granted-power value in centiwatts and a valid flag. The valid flag only rises once two consecutive decodes agree.

All outputs are plain status levels. They are not a stream: nothing is handshaked, so there is no back-pressure, and a consumer may sample the outputs whenever `pwr_valid_o` is high. Clock rate is a parameter (`CLK_HZ`). The period window and the timeout are derived from it.

Top module: `pwrind_decoder`

## Requirements
- R1: The synchronized line low means low impedance. The period is the number of clocks between falling edges. A period outside [PER_MIN, PER_MAX] decodes to state 5 (error), with PER_MIN = floor(CLK_HZ/990) and PER_MAX = floor(CLK_HZ/690). In state 5, `err_o` is high and `pwr_valid_o` is low.
- R2: An in-window period is sorted by its low time L and period P. If 8·L ≥ 5·P it is state 2 (75 %). If 8·L < 3·P it is state 4 (25 %). Otherwise it is state 3 (50 %).
- R3: With no line edge for TIMEOUT = 3·PER_MAX clocks, the block decodes a steady level: high gives state 0 (Hi-Z) and low gives state 1 (Low-Z). This decode repeats every TIMEOUT clocks while the line stays quiet.
- R4: `pwr_valid_o` rises only after two consecutive decodes give the same state. It is low in the very cycle `state_o` takes a new value.
- R5: In PoE mode (`aux_mode_i`=0), state 0 grants min(requested, 1300). Requested power by class 0..8, in centiwatts, is 1300, 384, 649, 1300, 2550, 4000, 5100, 6200, 7130. With `src_ext_i`=1, classes 5..8 request 3870, 5270, 7000, 9000 instead.
- R6: In PoE mode, state 1 grants 2550 for every class.
- R7: In PoE mode with `src_ext_i`=0, state 3 grants min(requested, 5100) and state 4 grants min(requested, 7130). With `src_ext_i`=1 these states have no mapping and `pwr_valid_o` stays low.
- R8: In PoE mode, state 2 with `src_ext_i`=1 and class 5..8 grants the full extended requested power. State 2 with `src_ext_i`=0 has no mapping.
- R9: In auxiliary mode (`aux_mode_i`=1), two cases grant the full requested power from the table chosen by `src_ext_i`: state 1 with class 0..4, and state 2 with class 5..8. Every other state/class pair has no mapping.
- R10: `power_cw_o` is 0 whenever `pwr_valid_o` is low. A `req_class_i` above 8 is treated as class 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Raw indicator line level (low = low impedance) |
| aux_mode_i | input | 1 | 1 = auxiliary supply operation, 0 = PoE operation |
| src_ext_i | input | 1 | 1 = extended-power source family, 0 = IEEE source |
| req_class_i | input | 4 | Configured requested class 0..8 |
| state_o | output | 3 | Decoded line state code (0..5) |
| err_o | output | 1 | Last decode was an out-of-window period |
| pwr_valid_o | output | 1 | Granted power is stable and defined |
| power_cw_o | output | 14 | Granted power in centiwatts |

## Verification
A falling edge on `line_i` passes through two synchronizer flops, an edge-detect register and the measurement register. `state_o` and the validity qualifier change on the fourth rising edge after the line changes. The power value then follows combinationally from class, mode and source inputs.

The bench drives whole periods and samples at falling clock edges in the high phase of the next period. That point is always dozens of clocks past the decode of the last finished period. The drop check sends exactly two new-pattern falls, so the check lands right after the first decode of the new state.

Timeout checks wait TIMEOUT+20 clocks after the last edge for a single steady decode, and 2·TIMEOUT+20 clocks for a confirmed one.

// File: rtl/pwrind_pkg.sv
package pwrind_pkg;

  typedef enum logic [2:0] {
    LS_HIZ  = 3'd0,
    LS_LOWZ = 3'd1,
    LS_D75  = 3'd2,
    LS_D50  = 3'd3,
    LS_D25  = 3'd4,
    LS_ERR  = 3'd5
  } line_state_e;

  localparam int PWR_W = 14;

  function automatic logic [3:0] clamp_class(input logic [3:0] cls);
    return (cls > 4'd8) ? 4'd8 : cls;
  endfunction

  function automatic logic [PWR_W-1:0] req_power(input logic [3:0] cls, input logic ext);
    logic [PWR_W-1:0] p;
    case (clamp_class(cls))
      4'd0:    p = 14'd1300;
      4'd1:    p = 14'd384;
      4'd2:    p = 14'd649;
      4'd3:    p = 14'd1300;
      4'd4:    p = 14'd2550;
      4'd5:    p = ext ? 14'd3870 : 14'd4000;
      4'd6:    p = ext ? 14'd5270 : 14'd5100;
      4'd7:    p = ext ? 14'd7000 : 14'd6200;
      default: p = ext ? 14'd9000 : 14'd7130;
    endcase
    return p;
  endfunction

  function automatic logic [PWR_W-1:0] cap_power(input logic [PWR_W-1:0] p,
                                                 input logic [PWR_W-1:0] lim);
    return (p < lim) ? p : lim;
  endfunction

endpackage

// File: rtl/pwrind_sync.sv
module pwrind_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (!rst_ni) pipe_q[g] <= 1'b1;
          else         pipe_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (!rst_ni) pipe_q[g] <= 1'b1;
          else         pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pwrind_meter.sv
module pwrind_meter #(
  parameter int TIMEOUT = 432,
  parameter int CW      = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  output logic          meas_v_o,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] low_o,
  output logic          steady_v_o,
  output logic          steady_lvl_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT - 1);

  logic          prev_q, ref_q, rose_q;
  logic [CW-1:0] cnt_q, low_q, tcnt_q;
  logic          fall, rise;

  assign fall = prev_q & ~lvl_i;
  assign rise = ~prev_q & lvl_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q       <= 1'b1;
      ref_q        <= 1'b0;
      rose_q       <= 1'b0;
      cnt_q        <= '0;
      low_q        <= '0;
      tcnt_q       <= '0;
      meas_v_o     <= 1'b0;
      period_o     <= '0;
      low_o        <= '0;
      steady_v_o   <= 1'b0;
      steady_lvl_o <= 1'b1;
    end else begin
      prev_q     <= lvl_i;
      meas_v_o   <= 1'b0;
      steady_v_o <= 1'b0;
      if (fall) begin
        if (ref_q && rose_q) begin
          meas_v_o <= 1'b1;
          period_o <= cnt_q;
          low_o    <= low_q;
        end
        cnt_q  <= CW'(1);
        ref_q  <= 1'b1;
        rose_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (rise) begin
          low_q  <= cnt_q;
          rose_q <= 1'b1;
          tcnt_q <= '0;
        end else if (tcnt_q == TO_LAST) begin
          steady_v_o   <= 1'b1;
          steady_lvl_o <= lvl_i;
          tcnt_q       <= '0;
          ref_q        <= 1'b0;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrind_classify.sv
module pwrind_classify
  import pwrind_pkg::*;
#(
  parameter int PER_MIN = 101,
  parameter int PER_MAX = 144,
  parameter int CW      = 9
) (
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] low_i,
  output line_state_e   state_o
);
  logic [CW+3:0] low8, per5, per3;

  always_comb begin
    low8 = {1'b0, low_i, 3'b000};
    per5 = ({4'b0, period_i} << 2) + {4'b0, period_i};
    per3 = ({4'b0, period_i} << 1) + {4'b0, period_i};
    if (int'(period_i) < PER_MIN || int'(period_i) > PER_MAX) state_o = LS_ERR;
    else if (low8 >= per5)                                    state_o = LS_D75;
    else if (low8 < per3)                                     state_o = LS_D25;
    else                                                      state_o = LS_D50;
  end
endmodule

// File: rtl/pwrind_map.sv
module pwrind_map
  import pwrind_pkg::*;
(
  input  line_state_e      state_i,
  input  logic [3:0]       class_i,
  input  logic             ext_i,
  input  logic             aux_i,
  output logic             ok_o,
  output logic [PWR_W-1:0] cw_o
);
  logic [3:0]       cls;
  logic [PWR_W-1:0] p_ieee, p_sel;

  always_comb begin
    cls    = clamp_class(class_i);
    p_ieee = req_power(cls, 1'b0);
    p_sel  = req_power(cls, ext_i);
    ok_o   = 1'b0;
    cw_o   = '0;
    if (aux_i) begin
      if ((state_i == LS_LOWZ && cls <= 4'd4) || (state_i == LS_D75 && cls >= 4'd5)) begin
        ok_o = 1'b1;
        cw_o = p_sel;
      end
    end else begin
      case (state_i)
        LS_HIZ:  begin ok_o = 1'b1; cw_o = cap_power(p_ieee, 14'd1300); end
        LS_LOWZ: begin ok_o = 1'b1; cw_o = 14'd2550; end
        LS_D75:  if (ext_i && cls >= 4'd5) begin ok_o = 1'b1; cw_o = p_sel; end
        LS_D50:  if (!ext_i) begin ok_o = 1'b1; cw_o = cap_power(p_ieee, 14'd5100); end
        LS_D25:  if (!ext_i) begin ok_o = 1'b1; cw_o = cap_power(p_ieee, 14'd7130); end
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwrind_decoder.sv
module pwrind_decoder
  import pwrind_pkg::*;
#(
  parameter int CLK_HZ      = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             aux_mode_i,
  input  logic             src_ext_i,
  input  logic [3:0]       req_class_i,
  output logic [2:0]       state_o,
  output logic             err_o,
  output logic             pwr_valid_o,
  output logic [PWR_W-1:0] power_cw_o
);
  localparam int PER_MIN = CLK_HZ / 990;
  localparam int PER_MAX = CLK_HZ / 690;
  localparam int TIMEOUT = 3 * PER_MAX;
  localparam int CW      = $clog2(TIMEOUT + 1);

  logic          lvl;
  logic          meas_v, steady_v, steady_lvl;
  logic [CW-1:0] per, low;
  line_state_e   cls_state, dec_state, state_q;
  logic          dec_v, seen_q, confirm_q, map_ok;
  logic [PWR_W-1:0] map_cw;

  pwrind_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(lvl)
  );

  pwrind_meter #(.TIMEOUT(TIMEOUT), .CW(CW)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
    .meas_v_o(meas_v), .period_o(per), .low_o(low),
    .steady_v_o(steady_v), .steady_lvl_o(steady_lvl)
  );

  pwrind_classify #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .CW(CW)) u_cls (
    .period_i(per), .low_i(low), .state_o(cls_state)
  );

  assign dec_v     = meas_v | steady_v;
  assign dec_state = steady_v ? (steady_lvl ? LS_HIZ : LS_LOWZ) : cls_state;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= LS_HIZ;
      seen_q    <= 1'b0;
      confirm_q <= 1'b0;
    end else if (dec_v) begin
      if (seen_q && dec_state == state_q) begin
        confirm_q <= 1'b1;
      end else begin
        state_q   <= dec_state;
        seen_q    <= 1'b1;
        confirm_q <= 1'b0;
      end
    end
  end

  pwrind_map u_map (
    .state_i(state_q), .class_i(req_class_i), .ext_i(src_ext_i),
    .aux_i(aux_mode_i), .ok_o(map_ok), .cw_o(map_cw)
  );

  assign state_o     = state_q;
  assign err_o       = (state_q == LS_ERR);
  assign pwr_valid_o = confirm_q & map_ok & (state_q != LS_ERR);
  assign power_cw_o  = pwr_valid_o ? map_cw : '0;
endmodule

// File: rtl/pwrind_decoder_chk.sv
module pwrind_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aux_mode_i,
  input logic [2:0]  state_o,
  input logic        err_o,
  input logic        pwr_valid_o,
  input logic [13:0] power_cw_o
);
  a_r4_drop_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> !pwr_valid_o);

  a_r1_err_blocks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pwr_valid_o);

  a_r10_zero_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_valid_o |-> (power_cw_o == 14'd0));

  a_r9_aux_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_valid_o && aux_mode_i) |-> (state_o == 3'd1 || state_o == 3'd2));

  a_r5_power_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_valid_o |-> (power_cw_o <= 14'd9000 && power_cw_o >= 14'd384));
endmodule

bind pwrind_decoder pwrind_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .aux_mode_i(aux_mode_i), .state_o(state_o),
  .err_o(err_o), .pwr_valid_o(pwr_valid_o), .power_cw_o(power_cw_o)
);

// File: tb/pwrind_decoder_tb.sv
module pwrind_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 100_000;
  localparam int TO         = 3 * (CLK_HZ / 690);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic aux = 1'b0;
  logic ext = 1'b0;
  logic [3:0] cls = 4'd0;
  logic [2:0] state;
  logic err, valid;
  logic [13:0] power;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrind_decoder #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .aux_mode_i(aux),
    .src_ext_i(ext), .req_class_i(cls), .state_o(state), .err_o(err),
    .pwr_valid_o(valid), .power_cw_o(power)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic train(input int low, input int per, input int n);
    for (int i = 0; i < n; i++) begin
      line = 1'b0;
      repeat (low) @(negedge clk);
      line = 1'b1;
      repeat (per - low) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R10 reset valid", valid, 0);
    check("R10 reset power", power, 0);
    check("R1 reset err", err, 0);
    check("R3 reset state", state, 0);
  endtask

  task automatic t_ext_75();
    aux = 0; ext = 1; cls = 4'd6;
    train(90, 120, 4);
    check("R8 ext 75 state", state, 2);
    check("R8 ext 75 valid", valid, 1);
    check("R8 ext 75 power", power, 5270);
    ext = 0;
    @(negedge clk);
    check("R8 ieee 75 unmapped", valid, 0);
  endtask

  task automatic t_ieee_switch();
    ext = 0; cls = 4'd7;
    train(60, 120, 3);
    check("R7 50 class7 power", power, 5100);
    train(30, 120, 2);
    check("R4 new state", state, 4);
    check("R4 drop at change", valid, 0);
    train(30, 120, 2);
    check("R4 confirmed", valid, 1);
    check("R7 25 class7 power", power, 6200);
    cls = 4'd8;
    @(negedge clk);
    check("R7 25 class8 power", power, 7130);
    ext = 1;
    @(negedge clk);
    check("R7 ext 25 unmapped", valid, 0);
    ext = 0;
  endtask

  task automatic t_duty_edges();
    train(80, 128, 3);
    check("R2 62.5 boundary", state, 2);
    train(79, 128, 3);
    check("R2 below 62.5", state, 3);
    train(48, 128, 3);
    check("R2 37.5 boundary", state, 3);
    train(47, 128, 3);
    check("R2 below 37.5", state, 4);
  endtask

  task automatic t_freq_edges();
    train(50, 101, 3);
    check("R1 min period ok", err, 0);
    train(50, 100, 3);
    check("R1 short period err", err, 1);
    check("R1 short period state", state, 5);
    check("R1 err valid low", valid, 0);
    train(72, 144, 3);
    check("R1 max period ok", state, 3);
    train(72, 145, 3);
    check("R1 long period err", state, 5);
  endtask

  task automatic t_timeout();
    cls = 4'd2;
    repeat (TO + 20) @(negedge clk);
    check("R3 first steady high", state, 0);
    check("R4 single steady not valid", valid, 0);
    repeat (TO) @(negedge clk);
    check("R3 steady high valid", valid, 1);
    check("R5 hiz class2", power, 649);
    cls = 4'd8;
    @(negedge clk);
    check("R5 hiz class8 cap", power, 1300);
    line = 1'b0;
    repeat (2 * TO + 20) @(negedge clk);
    check("R3 steady low state", state, 1);
    check("R6 lowz power", power, 2550);
  endtask

  task automatic t_aux();
    aux = 1; cls = 4'd3;
    @(negedge clk);
    check("R9 aux lowz class3", power, 1300);
    cls = 4'd6;
    @(negedge clk);
    check("R9 aux lowz class6 unmapped", valid, 0);
    line = 1'b1;
    repeat (20) @(negedge clk);
    cls = 4'd7; ext = 1;
    train(90, 120, 4);
    check("R9 aux 75 ext class7", power, 7000);
    ext = 0;
    @(negedge clk);
    check("R9 aux 75 ieee class7", power, 6200);
    cls = 4'd12;
    @(negedge clk);
    check("R10 class above 8", power, 7130);
    repeat (2 * TO + 20) @(negedge clk);
    check("R9 aux hiz unmapped", valid, 0);
    check("R10 invalid power zero", power, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_75();
    t_ieee_switch();
    t_duty_edges();
    t_freq_edges();
    t_timeout();
    t_aux();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule